// File: doc/BRIEF.md
# Multiprocessor Interrupt Distributor

This block collects interrupt lines from devices and from software, keeps the per-interrupt state, and tells each of up to eight CPUs which interrupt it should take next. The state it keeps for each interrupt is an enable bit, a pending bit, a trigger mode, a one-byte priority and, for shared interrupts, a one-byte CPU target mask. Software reaches this state through a simple 32-bit word-addressed register port. Each access carries the identifier of the CPU that makes it, so the first 32 interrupt IDs can be private to each CPU.

IDs 0-15 are software-generated interrupts. IDs 16-31 are per-CPU peripheral lines, sixteen for each CPU. IDs 32 and up are shared device lines that any set of CPUs can receive. For every CPU, the block picks the best eligible interrupt each cycle and registers its ID and priority on that CPU's output. A CPU interface or core downstream uses them.

Word address map (`bus_addr`): 0x000 control, 0x001 type (read-only), 0x002 software interrupt (write-only), 0x020+w enable-set, 0x040+w enable-clear, 0x060+w pending-set, 0x080+w pending-clear, 0x0C0+w trigger configuration, 0x100+w priority, 0x200+w targets.

Top module: `irq_distrib`

## Requirements
- R1: After reset, all enable and pending bits, all priorities, all targets and the control bit are 0. Every `cpu_irq` bit is 0, every `cpu_id` field is 1023 and every `cpu_prio` field is 0xFF.
- R2: Interrupt ID i is enabled through bit i%32 of enable word i/32. In the set view, a 1 enables the interrupt and a 0 has no effect. In the clear view, a 1 disables it and a 0 has no effect. Reading either view returns the current enable bits.
- R3: Enable and pending word 0 (IDs 0-31) is banked. An access reaches the copy of the CPU named by `bus_cpu`, and the copies of other CPUs are unchanged.
- R4: The trigger mode of ID i is the 2-bit field at bits 2*(i%16)+1:2*(i%16) of configuration word i/16. An upper bit of 1 selects rising edge and 0 selects level-high. For IDs 0-15 the fields read 2'b10 and writes to them are ignored.
- R5: Priority and target of ID i are byte i%4 of word i/4, with bits 8*(i%4)+7:8*(i%4). Target bit n selects CPU n. For the words covering IDs 0-31, each target byte reads as the accessing CPU's own bit, and IDs 0-31 are delivered only to their own CPU.
- R6: Bit 0 of the control word enables forwarding. While it is 0, every `cpu_irq` bit is 0 and every `cpu_id` field is 1023.
- R7: Bits 4:0 of the type word read NLINES/32-1.
- R8: A write to the software interrupt word sets pending the ID in bits 3:0 on every CPU n whose bit 16+n is 1.
- R9: An edge-mode interrupt latches pending on a 0-to-1 input transition and stays pending until it is cleared through the pending-clear view. A level-mode interrupt reads pending while its input is high, and a clear write does not remove it.
- R10: For each CPU, the outputs present the pending, enabled, targeted interrupt with the lowest priority value, with ties going to the lowest ID. When nothing is eligible the outputs show `cpu_irq`=0, ID 1023 and priority 0xFF. The outputs follow the state with one register stage.
- R11: When a rising edge and a pending-clear write for the same edge-mode ID meet in one cycle, the interrupt stays pending.
- R12: Pending-set writes make an ID pending (1 sets, 0 has no effect). Both pending views read the effective pending state, latched or level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address |
| bus_cpu | input | 3 | CPU making the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| spi_in | input | NLINES-32 | Shared device lines for IDs 32 and up |
| ppi_in | input | NCPU*16 | Per-CPU lines, CPU c uses bits 16c+15:16c for IDs 16-31 |
| cpu_irq | output | NCPU | An eligible interrupt exists for CPU c |
| cpu_id | output | NCPU*10 | Selected ID for CPU c at bits 10c+9:10c |
| cpu_prio | output | NCPU*8 | Selected priority for CPU c at bits 8c+7:8c |

## Verification
The function pair that can land in one cycle is a device line's rising edge and a software pending-clear to the same edge-mode ID. The bench drives the clear write and the line's rise on the same falling clock edge, so that both are seen at the next rising edge. It then judges the result by reading the pending view, which must still show the ID, and by a second clear, which must now remove it. The bench also checks priority ties and the fan-out of one software interrupt to several CPUs at the CPU outputs.

// File: rtl/irq_distrib.sv
module irq_distrib #(
  parameter int NCPU   = 4,
  parameter int NLINES = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [9:0]           bus_addr,
  input  logic [2:0]           bus_cpu,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NLINES-33:0]   spi_in,
  input  logic [NCPU*16-1:0]   ppi_in,
  output logic [NCPU-1:0]      cpu_irq,
  output logic [NCPU*10-1:0]   cpu_id,
  output logic [NCPU*8-1:0]    cpu_prio
);
  localparam int NID   = (NLINES > 1020) ? 1020 : NLINES;
  localparam int NSPI  = NLINES - 32;
  localparam int TYPEN = NLINES / 32 - 1;
  localparam logic [9:0] A_CTRL = 10'h000, A_TYPE = 10'h001, A_SGI = 10'h002;
  localparam logic [9:0] A_ENS = 10'h020, A_ENC = 10'h040, A_PNS = 10'h060, A_PNC = 10'h080;
  localparam logic [9:0] A_CFG = 10'h0C0, A_PRI = 10'h100, A_TGT = 10'h200;

  logic            ctrl_en;
  logic [31:0]     lena [NCPU];
  logic [31:0]     lpnd [NCPU];
  logic [NSPI-1:0] gena, gpnd, spi_q;
  logic [NCPU*16-1:0] ppi_q;
  logic [7:0]      prio [NID];
  logic [7:0]      tgt  [NSPI];
  logic [1:0]      cfg  [NID];

  logic [31:0]     effl [NCPU];
  logic [NSPI-1:0] effg;
  logic [31:0]     lense [NCPU], lencl [NCPU], lset [NCPU], lclr [NCPU];
  logic [NSPI-1:0] gense, gencl, gset, gclr;
  logic [9:0]      sid [NCPU];
  logic [7:0]      sp  [NCPU];
  logic            sv  [NCPU];

  wire wr_en  = bus_sel & bus_wr;
  wire sgi_wr = wr_en && (bus_addr == A_SGI);

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      effl[c] = lpnd[c];
      for (int b = 16; b < 32; b++)
        if (!cfg[b][1]) effl[c][b] = lpnd[c][b] | ppi_in[c*16+b-16];
    end
    for (int k = 0; k < NSPI; k++)
      effg[k] = gpnd[k] | (!cfg[32+k][1] & spi_in[k]);
  end

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      lense[c] = (wr_en && bus_addr == A_ENS && bus_cpu == 3'(c)) ? bus_wdata : 32'd0;
      lencl[c] = (wr_en && bus_addr == A_ENC && bus_cpu == 3'(c)) ? bus_wdata : 32'd0;
      lclr[c]  = (wr_en && bus_addr == A_PNC && bus_cpu == 3'(c)) ? bus_wdata : 32'd0;
      lset[c]  = (wr_en && bus_addr == A_PNS && bus_cpu == 3'(c)) ? bus_wdata : 32'd0;
      if (sgi_wr && bus_wdata[16+c]) lset[c] = lset[c] | (32'd1 << bus_wdata[3:0]);
      for (int b = 16; b < 32; b++)
        if (cfg[b][1] && ppi_in[c*16+b-16] && !ppi_q[c*16+b-16]) lset[c][b] = 1'b1;
    end
    for (int k = 0; k < NSPI; k++) begin
      gense[k] = wr_en && bus_addr == 10'(A_ENS + (k+32)/32) && bus_wdata[(k+32)%32];
      gencl[k] = wr_en && bus_addr == 10'(A_ENC + (k+32)/32) && bus_wdata[(k+32)%32];
      gclr[k]  = wr_en && bus_addr == 10'(A_PNC + (k+32)/32) && bus_wdata[(k+32)%32];
      gset[k]  = (wr_en && bus_addr == 10'(A_PNS + (k+32)/32) && bus_wdata[(k+32)%32])
               | (cfg[32+k][1] && spi_in[k] && !spi_q[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      gena    <= '0;
      gpnd    <= '0;
      spi_q   <= '0;
      ppi_q   <= '0;
      for (int c = 0; c < NCPU; c++) begin
        lena[c] <= '0;
        lpnd[c] <= '0;
      end
      for (int i = 0; i < NID; i++) begin
        prio[i] <= '0;
        cfg[i]  <= (i < 16) ? 2'b10 : 2'b00;
      end
      for (int k = 0; k < NSPI; k++) tgt[k] <= '0;
    end else begin
      spi_q <= spi_in;
      ppi_q <= ppi_in;
      if (wr_en && bus_addr == A_CTRL) ctrl_en <= bus_wdata[0];
      for (int c = 0; c < NCPU; c++) begin
        lena[c] <= (lena[c] & ~lencl[c]) | lense[c];
        lpnd[c] <= (lpnd[c] & ~lclr[c]) | lset[c];
      end
      gena <= (gena & ~gencl) | gense;
      gpnd <= (gpnd & ~gclr) | gset;
      for (int i = 0; i < NID; i++)
        if (wr_en && bus_addr == 10'(A_PRI + i/4)) prio[i] <= bus_wdata[8*(i%4) +: 8];
      for (int k = 0; k < NSPI; k++)
        if (wr_en && bus_addr == 10'(A_TGT + (k+32)/4)) tgt[k] <= bus_wdata[8*((k+32)%4) +: 8];
      for (int i = 16; i < NID; i++)
        if (wr_en && bus_addr == 10'(A_CFG + i/16)) cfg[i] <= bus_wdata[2*(i%16) +: 2];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) bus_rdata[0] = ctrl_en;
    if (bus_addr == A_TYPE) bus_rdata[4:0] = 5'(TYPEN);
    for (int c = 0; c < NCPU; c++)
      if (bus_cpu == 3'(c)) begin
        if (bus_addr == A_ENS || bus_addr == A_ENC) bus_rdata = lena[c];
        if (bus_addr == A_PNS || bus_addr == A_PNC) bus_rdata = effl[c];
        if (bus_addr >= A_TGT && bus_addr < 10'(A_TGT + 8)) bus_rdata = {4{8'd1 << c}};
      end
    for (int k = 0; k < NSPI; k++) begin
      if (bus_addr == 10'(A_ENS + (k+32)/32) || bus_addr == 10'(A_ENC + (k+32)/32))
        bus_rdata[(k+32)%32] = gena[k];
      if (bus_addr == 10'(A_PNS + (k+32)/32) || bus_addr == 10'(A_PNC + (k+32)/32))
        bus_rdata[(k+32)%32] = effg[k];
      if (bus_addr == 10'(A_TGT + (k+32)/4)) bus_rdata[8*((k+32)%4) +: 8] = tgt[k];
    end
    for (int i = 0; i < NID; i++) begin
      if (bus_addr == 10'(A_PRI + i/4)) bus_rdata[8*(i%4) +: 8] = prio[i];
      if (bus_addr == 10'(A_CFG + i/16)) bus_rdata[2*(i%16) +: 2] = cfg[i];
    end
  end

  always_comb begin
    for (int c = 0; c < NCPU; c++) begin
      sv[c]  = 1'b0;
      sp[c]  = 8'hFF;
      sid[c] = 10'd1023;
      for (int b = 0; b < 32; b++)
        if (ctrl_en && lena[c][b] && effl[c][b] && (!sv[c] || prio[b] < sp[c])) begin
          sv[c]  = 1'b1;
          sp[c]  = prio[b];
          sid[c] = 10'(b);
        end
      for (int k = 0; k < NID - 32; k++)
        if (ctrl_en && gena[k] && effg[k] && tgt[k][c] && (!sv[c] || prio[32+k] < sp[c])) begin
          sv[c]  = 1'b1;
          sp[c]  = prio[32+k];
          sid[c] = 10'(32 + k);
        end
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCPU; c++) begin
      if (!rst_n) begin
        cpu_irq[c]          <= 1'b0;
        cpu_id[c*10 +: 10]  <= 10'd1023;
        cpu_prio[c*8 +: 8]  <= 8'hFF;
      end else begin
        cpu_irq[c]          <= sv[c];
        cpu_id[c*10 +: 10]  <= sid[c];
        cpu_prio[c*8 +: 8]  <= sp[c];
      end
    end
  end
endmodule

// File: rtl/irq_distrib_chk.sv
module irq_distrib_chk #(
  parameter int NCPU   = 4,
  parameter int NLINES = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [9:0]         bus_addr,
  input logic [2:0]         bus_cpu,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic [NCPU-1:0]    cpu_irq,
  input logic [NCPU*10-1:0] cpu_id,
  input logic               ctrl_en
);
  AST_FWD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> (cpu_irq == '0)); // R6
  AST_TYPE_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 10'h001) |-> (bus_rdata[4:0] == 5'(NLINES/32 - 1))); // R7
  AST_SGI_CFG_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 10'h0C0) |-> (bus_rdata == 32'hAAAA_AAAA)); // R4
  AST_ENCLR_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 10'h040 && bus_cpu == 3'd0 && bus_wdata == 32'hFFFF_FFFF)
      |=> ##1 (!cpu_irq[0] || cpu_id[9:0] >= 10'd32)); // R2
endmodule

bind irq_distrib irq_distrib_chk #(.NCPU(NCPU), .NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_cpu(bus_cpu), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .cpu_irq(cpu_irq), .cpu_id(cpu_id), .ctrl_en(ctrl_en)
);

// File: tb/sim_irq_distrib.sv
module sim_irq_distrib;
  localparam int NCPU = 4;
  localparam int NLINES = 64;
  localparam int NV = 22;
  // {write, cpu, addr, data, requirement}
  localparam logic [49:0] VEC [NV] = '{
    {1'b1, 3'd0, 10'h021, 32'h0000_00F1, 4'd2},  // R2 set view
    {1'b0, 3'd0, 10'h021, 32'h0000_00F1, 4'd2},
    {1'b1, 3'd0, 10'h041, 32'h0000_0011, 4'd2},  // R2 clear view
    {1'b0, 3'd0, 10'h041, 32'h0000_00E0, 4'd2},
    {1'b0, 3'd0, 10'h021, 32'h0000_00E0, 4'd2},
    {1'b1, 3'd1, 10'h020, 32'h0000_0005, 4'd3},  // R3 banked
    {1'b0, 3'd1, 10'h020, 32'h0000_0005, 4'd3},
    {1'b0, 3'd0, 10'h020, 32'h0000_0000, 4'd3},
    {1'b1, 3'd0, 10'h0C2, 32'h0000_0008, 4'd4},  // R4 id33 edge
    {1'b0, 3'd0, 10'h0C2, 32'h0000_0008, 4'd4},
    {1'b1, 3'd0, 10'h0C0, 32'hFFFF_FFFF, 4'd4},  // R4 read-only
    {1'b0, 3'd0, 10'h0C0, 32'hAAAA_AAAA, 4'd4},
    {1'b1, 3'd0, 10'h0C1, 32'h0000_0002, 4'd4},
    {1'b0, 3'd0, 10'h0C1, 32'h0000_0002, 4'd4},
    {1'b1, 3'd0, 10'h108, 32'h4433_2211, 4'd5},  // R5 priority
    {1'b0, 3'd0, 10'h108, 32'h4433_2211, 4'd5},
    {1'b1, 3'd0, 10'h208, 32'h0F02_0100, 4'd5},  // R5 targets
    {1'b0, 3'd0, 10'h208, 32'h0F02_0100, 4'd5},
    {1'b0, 3'd2, 10'h200, 32'h0404_0404, 4'd5},
    {1'b0, 3'd0, 10'h001, 32'h0000_0001, 4'd7},  // R7 type
    {1'b1, 3'd0, 10'h000, 32'h0000_0001, 4'd6},  // R6 control
    {1'b0, 3'd0, 10'h000, 32'h0000_0001, 4'd6}
  };

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [9:0] bus_addr = '0;
  logic [2:0] bus_cpu = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NLINES-33:0] spi_in = '0;
  logic [NCPU*16-1:0] ppi_in = '0;
  logic [NCPU-1:0] cpu_irq;
  logic [NCPU*10-1:0] cpu_id;
  logic [NCPU*8-1:0] cpu_prio;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_distrib #(.NCPU(NCPU), .NLINES(NLINES)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_cpu(bus_cpu), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_in(spi_in), .ppi_in(ppi_in), .cpu_irq(cpu_irq), .cpu_id(cpu_id), .cpu_prio(cpu_prio));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] c, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_cpu = c; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] c, input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_cpu = c; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic rdchk(input string tag, input logic [2:0] c, input logic [9:0] a, input logic [31:0] e);
    logic [31:0] d;
    rd(c, a, d);
    check(tag, d, e);
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic outchk(input string tag, input int c, input logic irq, input logic [9:0] id, input logic [7:0] p);
    check({tag, " irq"}, 32'(cpu_irq[c]), 32'(irq));
    check({tag, " id"}, 32'(cpu_id[c*10 +: 10]), 32'(id));
    check({tag, " prio"}, 32'(cpu_prio[c*8 +: 8]), 32'(p));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int c = 0; c < NCPU; c++) outchk("R1 reset", c, 1'b0, 10'd1023, 8'hFF);
    rdchk("R1 ctrl", 3'd0, 10'h000, 32'h0);
    rdchk("R1 pending", 3'd0, 10'h061, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][49]) wr(VEC[i][48:46], VEC[i][45:36], VEC[i][35:4]);
      else begin
        rd(VEC[i][48:46], VEC[i][45:36], d);
        check($sformatf("R%0d table %0d", VEC[i][3:0], i), d, VEC[i][35:4]);
      end
    end

    // R10 priority selection and tie break
    wr(3'd0, 10'h209, 32'h0101_0100);
    wr(3'd0, 10'h109, 32'h2020_3000);
    spi_in[5] = 1; spi_in[6] = 1; spi_in[7] = 1;
    settle();
    outchk("R10 tie lowest id", 0, 1'b1, 10'd38, 8'h20);
    outchk("R10 untargeted cpu", 1, 1'b0, 10'd1023, 8'hFF);
    spi_in[6] = 0;
    settle();
    outchk("R10 next", 0, 1'b1, 10'd39, 8'h20);
    spi_in[7] = 0;
    settle();
    outchk("R10 last", 0, 1'b1, 10'd37, 8'h30);

    // R6 forwarding off
    wr(3'd0, 10'h000, 32'h0);
    settle();
    outchk("R6 off", 0, 1'b0, 10'd1023, 8'hFF);
    wr(3'd0, 10'h000, 32'h1);

    // R9 level behaviour
    rdchk("R9 level pend", 3'd0, 10'h061, 32'h0000_0020);
    wr(3'd0, 10'h081, 32'h0000_0020);
    rdchk("R9 level clr no effect", 3'd0, 10'h061, 32'h0000_0020);
    spi_in[5] = 0;
    rdchk("R9 level low", 3'd0, 10'h061, 32'h0);

    // R9 edge behaviour on id33
    wr(3'd0, 10'h021, 32'h0000_0002);
    @(negedge clk); spi_in[1] = 1;
    @(negedge clk); spi_in[1] = 0;
    rdchk("R9 edge latched", 3'd0, 10'h061, 32'h0000_0002);
    settle();
    outchk("R9 edge out", 0, 1'b1, 10'd33, 8'h22);
    wr(3'd0, 10'h081, 32'h0000_0002);
    rdchk("R9 edge cleared", 3'd0, 10'h061, 32'h0);

    // R11 rising edge and clear in one cycle
    @(negedge clk);
    spi_in[1] = 1;
    bus_sel = 1; bus_wr = 1; bus_cpu = 3'd0; bus_addr = 10'h081; bus_wdata = 32'h2;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    rdchk("R11 edge wins", 3'd0, 10'h061, 32'h0000_0002);
    wr(3'd0, 10'h081, 32'h0000_0002);
    rdchk("R11 second clear", 3'd0, 10'h061, 32'h0);
    spi_in[1] = 0;

    // R8 software interrupt fan-out
    wr(3'd0, 10'h020, 32'h0000_0008);
    wr(3'd2, 10'h020, 32'h0000_0008);
    wr(3'd0, 10'h002, 32'h0005_0003);
    rdchk("R8 cpu0 pend", 3'd0, 10'h060, 32'h0000_0008);
    rdchk("R8 cpu2 pend", 3'd2, 10'h060, 32'h0000_0008);
    rdchk("R8 cpu1 not listed", 3'd1, 10'h060, 32'h0);
    settle();
    outchk("R8 cpu0", 0, 1'b1, 10'd3, 8'h00);
    outchk("R8 cpu2", 2, 1'b1, 10'd3, 8'h00);
    outchk("R8 cpu1", 1, 1'b0, 10'd1023, 8'hFF);

    // R12 pending-set view, banked per CPU (R3)
    wr(3'd1, 10'h060, 32'h0000_0004);
    settle();
    outchk("R12 set view", 1, 1'b1, 10'd2, 8'h00);
    rdchk("R12 cpu3 untouched", 3'd3, 10'h060, 32'h0);
    wr(3'd1, 10'h080, 32'h0000_0004);
    settle();
    outchk("R12 clear view", 1, 1'b0, 10'd1023, 8'hFF);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule